// File: doc/BRIEF.md
# ATA PIO Register Cycle Engine

This block performs one register access on a 16-bit parallel ATA drive bus at a time, in programmed I/O style. A request names one of the drive's task-file registers with a 5-bit selector, says whether it is a read or a write, and carries the write word. The engine drives the chip selects and register address, then pulses the active-low read or write strobe, then returns every control line to its inactive level. It ends the request with a one-clock acknowledge. Read data is captured from the bus while the strobe is still low and presented with a one-clock valid pulse.

Each phase has a length set by its own cycle count: address setup, strobe active and recovery. These counts are taken when the request is accepted. A burst request reads the data register a given number of times. It sets the address up once, holds it while the strobes repeat with a recovery gap between them, and releases the bus after the last word. The bus is split into an output word, an output enable and an input word; the pad level combines them. The engine drives the bus only during write accesses.

Top module: `ata_regcycle_engine`

## Requirements
- R1: The selector is {cs1, cs0, a2, a1, a0} from bit 4 down to bit 0. During an access, dev_cs1_n is the inverse of bit 4, dev_cs0_n is the inverse of bit 3, and dev_addr is bits 2..0. A selector is legal when cs0 alone is set, with any address, or when cs1 alone is set with address 110 or 111.
- R2: A non-burst request with an illegal selector gives, on the next clock, one ack cycle with ack_err high. No strobe, chip select or bus drive occurs.
- R3: After acceptance, the chip selects and address are driven with both strobes high for max(t_setup,1) clocks before the first strobe.
- R4: Each strobe stays low for max(t_active,1) clocks. Read and write strobes are never low together.
- R5: After the last strobe, every control line is inactive (both chip selects high, address 000, both strobes high) for max(t_recover,1) clocks. Then ack is high for exactly one clock with all control lines still inactive.
- R6: A read captures dev_din on the clock edge that ends the last strobe-low clock. rd_data shows that word while rd_valid is high for one clock.
- R7: A write drives req_wdata on dev_dout with dev_doe high while the write strobe is low. dev_doe is never high during a read or burst access.
- R8: A burst reads the data register (selector 01000) whatever req_sel holds. It makes max(req_words,1) strobes, with the selector held between strobes. The gaps between strobes are max(t_recover,1) clocks. It gives one rd_valid per word and a single ack at the end.
- R9: While reset is asserted and after it is released, busy, ack, rd_valid and dev_doe are low, both chip selects and both strobes are high, and dev_addr is 000.
- R10: A request raised while busy is high is ignored. It changes neither the access in progress nor the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, taken when busy is low |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_burst | input | 1 | 1 = repeated data-register read |
| req_sel | input | 5 | Register selector {cs1, cs0, a2, a1, a0} |
| req_wdata | input | DW | Word to write |
| req_words | input | CW | Burst word count, 0 treated as 1 |
| t_setup | input | TW | Address setup clocks, 0 treated as 1 |
| t_active | input | TW | Strobe-low clocks, 0 treated as 1 |
| t_recover | input | TW | Recovery clocks, 0 treated as 1 |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-clock end-of-request pulse |
| ack_err | output | 1 | Qualifies ack: selector was rejected |
| rd_data | output | DW | Last word read |
| rd_valid | output | 1 | One-clock pulse with each read word |
| dev_cs0_n | output | 1 | Drive chip select 0, active low |
| dev_cs1_n | output | 1 | Drive chip select 1, active low |
| dev_addr | output | 3 | Drive register address, active high |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | DW | Data driven to the bus |
| dev_doe | output | 1 | Output enable for dev_dout |
| dev_din | input | DW | Data sampled from the bus |

## Verification
The assertions expect the requester to present a request only as a one-clock pulse or while the engine is idle. They also expect dev_din to be a clean synchronous input, so that any value is legal at the capture edge. The stimulus raises req for a single clock at a falling edge and changes dev_din only at falling edges. The one exception is a directed case that raises req again during an access, with an illegal selector, to show that it is ignored. Random timing counts include zero, so the minimum-length phases are covered. Burst lengths are drawn small, with directed cases for a count of zero and for a long burst.

// File: rtl/ata_regcycle_engine.sv
module ata_regcycle_engine #(
  parameter int DW = 16,
  parameter int TW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [4:0]    req_sel,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] req_words,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_active,
  input  logic [TW-1:0] t_recover,
  output logic          busy,
  output logic          ack,
  output logic          ack_err,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          dev_cs0_n,
  output logic          dev_cs1_n,
  output logic [2:0]    dev_addr,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic [DW-1:0] dev_dout,
  output logic          dev_doe,
  input  logic [DW-1:0] dev_din
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_RECOV} st_t;

  localparam logic [4:0] DATA_SEL = 5'b01000;

  st_t           st;
  logic [TW-1:0] cnt, ta_q, tr_q;
  logic [CW-1:0] left;
  logic [4:0]    sel_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic          hold_bus, strobe;

  function automatic logic sel_ok(input logic [4:0] s);
    case (s[4:3])
      2'b01:   return 1'b1;
      2'b10:   return s[2:1] == 2'b11;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [TW-1:0] last_of(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign busy     = st != S_IDLE;
  assign strobe   = st == S_STROBE;
  assign hold_bus = st == S_SETUP || strobe || (st == S_RECOV && left > 1);

  assign dev_cs0_n = ~(hold_bus & sel_q[3]);
  assign dev_cs1_n = ~(hold_bus & sel_q[4]);
  assign dev_addr  = hold_bus ? sel_q[2:0] : 3'b000;
  assign dev_rd_n  = ~(strobe & ~wr_q);
  assign dev_wr_n  = ~(strobe & wr_q);
  assign dev_doe   = busy & wr_q;
  assign dev_dout  = dev_doe ? wdata_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ta_q     <= '0;
      tr_q     <= '0;
      left     <= '0;
      sel_q    <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      ack      <= 1'b0;
      ack_err  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      ack      <= 1'b0;
      ack_err  <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          if (!req_burst && !sel_ok(req_sel)) begin
            ack     <= 1'b1;
            ack_err <= 1'b1;
          end else begin
            sel_q   <= req_burst ? DATA_SEL : req_sel;
            wr_q    <= req_write & ~req_burst;
            wdata_q <= req_wdata;
            ta_q    <= t_active;
            tr_q    <= t_recover;
            left    <= (req_burst && req_words != '0) ? req_words : CW'(1);
            cnt     <= last_of(t_setup);
            st      <= S_SETUP;
          end
        end
        S_SETUP:
          if (cnt == '0) begin
            cnt <= last_of(ta_q);
            st  <= S_STROBE;
          end else cnt <= cnt - 1'b1;
        S_STROBE:
          if (cnt == '0) begin
            if (!wr_q) begin
              rd_data  <= dev_din;
              rd_valid <= 1'b1;
            end
            cnt <= last_of(tr_q);
            st  <= S_RECOV;
          end else cnt <= cnt - 1'b1;
        S_RECOV:
          if (cnt == '0) begin
            if (left > 1) begin
              left <= left - 1'b1;
              cnt  <= last_of(ta_q);
              st   <= S_STROBE;
            end else begin
              ack <= 1'b1;
              st  <= S_IDLE;
            end
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n));

  p_strobe_has_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> (dev_cs0_n != dev_cs1_n));

  p_sel_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n && $past(!dev_rd_n)) |-> ($stable(dev_addr) && $stable(dev_cs0_n) && $stable(dev_cs1_n)));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd_n |-> !dev_doe);

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && dev_addr == 3'b000));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (ack && !busy));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(dev_rd_n));

endmodule

// File: tb/ata_regcycle_engine_tb.sv
module ata_regcycle_engine_tb;
  localparam int DW = 16, TW = 4, CW = 8;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_write = 0, req_burst = 0;
  logic [4:0] req_sel = 0;
  logic [DW-1:0] req_wdata = 0, dev_din = 0;
  logic [CW-1:0] req_words = 0;
  logic [TW-1:0] t_setup = 0, t_active = 0, t_recover = 0;
  logic busy, ack, ack_err, rd_valid, dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_doe;
  logic [DW-1:0] rd_data, dev_dout;
  logic [2:0] dev_addr;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  ata_regcycle_engine #(.DW(DW), .TW(TW), .CW(CW)) u_dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  function automatic int atleast1(input int v);
    return v == 0 ? 1 : v;
  endfunction

  function automatic bit legal(input logic [4:0] s);
    return (s[4:3] == 2'b01) || (s[4:3] == 2'b10 && s[2:1] == 2'b11);
  endfunction

  task automatic run(input logic [4:0] sel, input bit wr, input bit burst, input int words,
                     input int s, input int p, input int r, input logic [DW-1:0] wd, input bit poke);
    int se = atleast1(s), pe = atleast1(p), re = atleast1(r);
    int nw = burst ? atleast1(words) : 1;
    logic [4:0] esel = burst ? 5'b01000 : sel;
    bit iswr = wr && !burst;
    bit err = !burst && !legal(sel);
    int setup_n = 0, strobes = 0, cur = 0, gap = 0, n = 0, rv = 0, acks = 0;
    int bad_w = 0, bad_g = 0, bad_sel = 0, bad_rel = 0, bad_wd = 0, bad_oe = 0, bad_rd = 0;
    logic [DW-1:0] last_din = 0;
    @(negedge clk);
    req = 1; req_sel = sel; req_write = wr; req_burst = burst; req_words = CW'(words);
    t_setup = TW'(s); t_active = TW'(p); t_recover = TW'(r); req_wdata = wd;
    @(negedge clk);
    req = 0;
    t_setup = TW'($urandom); t_active = TW'($urandom); t_recover = TW'($urandom);
    req_sel = 5'($urandom); req_wdata = DW'($urandom); req_words = CW'($urandom);
    forever begin
      bit low = !dev_rd_n || !dev_wr_n;
      bit csmatch = dev_cs1_n == !esel[4] && dev_cs0_n == !esel[3] && dev_addr == esel[2:0];
      bit rel = dev_cs0_n && dev_cs1_n && dev_addr == 0 && dev_rd_n && dev_wr_n;
      n++;
      if (poke && n == 1) begin req = 1; req_sel = 5'b11000; req_burst = 0; end
      if (poke && n == 2) req = 0;
      if (dev_doe && !iswr) bad_oe++;
      if (rd_valid) begin
        rv++;
        if (rd_data != last_din) bad_rd++;
      end
      if (ack) break;
      if (err) bad_rel++;
      if (low) begin
        if (cur == 0) begin
          strobes++;
          if (strobes > 1 && gap != re) bad_g++;
        end
        cur++; gap = 0;
        if (!csmatch) bad_sel++;
        if (iswr && (!dev_doe || dev_dout != wd || dev_wr_n)) bad_wd++;
        if (!iswr && dev_rd_n) bad_wd++;
        dev_din = DW'($urandom); last_din = dev_din;
      end else begin
        if (cur > 0 && cur != pe) bad_w++;
        cur = 0;
        if (strobes == 0) begin
          setup_n++;
          if (!csmatch) bad_sel++;
        end else begin
          gap++;
          if (strobes < nw && !csmatch) bad_sel++;
          if (strobes >= nw && !rel) bad_rel++;
        end
        dev_din = DW'($urandom);
      end
      if (n > 9000) break;
      @(negedge clk);
    end
    acks = ack;
    if (err) begin
      chk(ack && ack_err && n == 1 && bad_rel == 0, "R2 illegal selector", n, 1);
    end else begin
      chk(!ack_err, "R2 legal selector no error", ack_err, 0);
      chk(setup_n == se, "R3 setup clocks", setup_n, se);
      chk(bad_w == 0, "R4 strobe width", bad_w, 0);
      chk(bad_sel == 0, "R1 selector on bus", bad_sel, 0);
      chk(gap == re && bad_rel == 0, "R5 recovery", gap, re);
      chk(strobes == nw && bad_g == 0, "R8 strobe count and gaps", strobes, nw);
      chk(rv == (iswr ? 0 : nw) && bad_rd == 0, "R6 read capture", bad_rd, 0);
      chk(bad_wd == 0 && bad_oe == 0, "R7 write drive", bad_wd + bad_oe, 0);
    end
    chk(rel_now(), "R5 released at ack", acks, 1);
    @(negedge clk);
    chk(!ack, "R5 ack single clock", ack, 0);
    if (poke) begin
      repeat (20) begin
        if (ack || busy || !dev_cs0_n || !dev_cs1_n) bad_rel++;
        @(negedge clk);
      end
      chk(bad_rel == 0, "R10 request while busy ignored", bad_rel, 0);
    end
  endtask

  function automatic bit rel_now();
    return dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && dev_addr == 0;
  endfunction

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk(!busy && !ack && !rd_valid && !dev_doe && rel_now(), "R9 in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !ack && !dev_doe && rel_now(), "R9 after reset", busy, 0);

    run(5'b01111, 0, 0, 0, 0, 0, 0, 16'h0, 0);
    run(5'b01110, 1, 0, 0, 15, 15, 15, 16'hA5C3, 0);
    run(5'b10110, 1, 0, 0, 2, 3, 1, 16'h00E0, 0);
    run(5'b10111, 0, 0, 0, 1, 1, 1, 16'h0, 0);
    run(5'b10000, 0, 0, 0, 3, 3, 3, 16'h0, 0);
    run(5'b11111, 1, 0, 0, 3, 3, 3, 16'h1234, 0);
    run(5'b00011, 0, 0, 0, 3, 3, 3, 16'h0, 0);
    run(5'b00000, 0, 1, 0, 2, 2, 2, 16'h0, 0);
    run(5'b11111, 1, 1, 4, 0, 2, 0, 16'hFFFF, 0);
    run(5'b01000, 0, 1, 255, 1, 1, 1, 16'h0, 0);
    run(5'b01010, 0, 0, 0, 2, 2, 2, 16'h0, 1);

    for (int i = 0; i < 60; i++) begin
      logic [4:0] s = 5'($urandom);
      if ($urandom % 3 != 0) s = {2'b01, 3'($urandom)};
      run(s, 1'($urandom), ($urandom % 4) == 0, int'($urandom % 12),
          int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
          DW'($urandom), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule